// File: doc/BRIEF.md
# Raster Timing Generator

This block produces the horizontal and vertical scan timing for a display pipe. Software programs six timing words through a small register port, one word for each of the active/total, blank and sync windows on each axis. Every word holds two 16-bit positions stored as the position minus one. A pixel counter and a line counter run on the pixel clock and drive registered hsync, vsync, blank and active-video outputs, together with the counter values they belong to.

A power-state input picks one of five display power modes. Each mode independently gates the video, the horizontal sync and the vertical sync, and drives a DAC power-down line and a panel power line. A control word enables the counters, selects the polarity of each sync, and chooses whether new timing takes effect at once or at the next frame boundary. All configuration writes are refused until a key has been written to the lock register.

Top module: `raster_timing_gen`

## Requirements
- R1: While reset is held, both counter outputs are zero, blank is 1, video_active is 0, hsync and vsync are 1 (the idle level for the reset polarity of 0), dac_pwrdn is 1 and panel_on is 0.
- R2: The register addresses are: 0 lock, 1 control, 2 horizontal total/active, 3 horizontal blank, 4 horizontal sync, 5 vertical total/active, 6 vertical blank, 7 vertical sync. Each timing word holds the first position minus one in bits 15:0 and the second in bits 31:16 (active/total, start/end). A read returns the stored word unchanged, and other addresses read as zero.
- R3: A write of 0x0000A5C3 to address 0 unlocks the configuration, and any other value written there locks it. Address 0 reads 1 when unlocked and 0 when locked. Writes to addresses 1 to 7 while locked are ignored. Reset leaves the configuration locked.
- R4: Control bit 0 enables the counters. While it is 0, the counter outputs are 0, blank is 1 and both syncs sit at their idle level.
- R5: The pixel counter counts 0 up to the total field (total minus one) and then wraps to 0. The line counter advances on each wrap and wraps to 0 after its own total field.
- R6: blank is 1 when the pixel count is above the horizontal blank-start field and at or below the blank-end field, or when the line count meets the same test against the vertical blank fields. It is also 1 when the power state turns video off.
- R7: A sync is in its pulse when its counter is above the sync-start field and at or below the sync-end field. Control bit 1 (horizontal) and bit 2 (vertical) make the pulse level 1 when set and 0 when clear. The idle level is the opposite.
- R8: pwr_state 0 turns on video, hsync and vsync. State 1 turns on both syncs only. State 2 turns on hsync only. State 3 turns on vsync only. State 4 and the unused codes 5 to 7 turn everything off. A disabled sync stays at its idle level. dac_pwrdn is 0 only when both syncs are on. panel_on is 0 only in the off states.
- R9: With control bit 3 set, a timing write takes effect on the following cycle. With bit 3 clear, the new word is held and takes effect when the counters wrap from the last pixel of the last line.
- R10: video_active is 1 when the pixel count is at or below the horizontal active field and the line count is at or below the vertical active field, with the counters enabled. It does not depend on the power state.
- R11: All outputs are registered. Each sample shows hcount, vcount and the sync, blank and active levels that belong to that same counter position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational on cfg_addr) |
| pwr_state | input | 3 | Display power mode |
| hcount | output | 16 | Pixel position of the current sample |
| vcount | output | 16 | Line position of the current sample |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| blank | output | 1 | Blanking |
| video_active | output | 1 | Inside the active display area |
| dac_pwrdn | output | 1 | DAC power-down request |
| panel_on | output | 1 | Panel power enable |

## Verification
The main raster function runs through whole frames of a small 10-by-7 raster under several patterns. The first pattern uses the default idle-high syncs. Two more patterns each invert one sync polarity, which shows whether the polarity bits act on their own axis only. A sweep over all eight power codes covers every mode and the unused codes, and separates the gating of hsync, vsync and video from the DAC and panel lines. Mid-frame rewrites of the total and sync words, first deferred and then immediate, show whether a change lands at the frame wrap or on the next cycle. The lock sequence shows that refused writes leave the stored words unchanged.

// File: rtl/raster_timing_gen.sv
module raster_timing_gen #(
  parameter int          DW         = 32,
  parameter int          AW         = 4,
  parameter logic [31:0] UNLOCK_KEY = 32'h0000_A5C3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  input  logic [2:0]    pwr_state,
  output logic [DW/2-1:0] hcount,
  output logic [DW/2-1:0] vcount,
  output logic          hsync,
  output logic          vsync,
  output logic          blank,
  output logic          video_active,
  output logic          dac_pwrdn,
  output logic          panel_on
);
  localparam int FW     = DW / 2;
  localparam int NT     = 6;
  localparam int CTRL_W = 4;
  localparam int A_LOCK = 0;
  localparam int A_CTRL = 1;
  localparam int A_TIM  = 2;

  logic              unlocked;
  logic [CTRL_W-1:0] ctrl;
  logic [NT-1:0][DW-1:0] pend, act;
  logic [FW-1:0]     h, v;

  wire en   = ctrl[0];
  wire hpol = ctrl[1];
  wire vpol = ctrl[2];
  wire upd  = ctrl[3];
  wire wr_ok = cfg_we && unlocked;

  wire [FW-1:0] hact = act[0][FW-1:0];
  wire [FW-1:0] htot = act[0][DW-1:FW];
  wire [FW-1:0] hbs  = act[1][FW-1:0];
  wire [FW-1:0] hbe  = act[1][DW-1:FW];
  wire [FW-1:0] hss  = act[2][FW-1:0];
  wire [FW-1:0] hse  = act[2][DW-1:FW];
  wire [FW-1:0] vact = act[3][FW-1:0];
  wire [FW-1:0] vtot = act[3][DW-1:FW];
  wire [FW-1:0] vbs  = act[4][FW-1:0];
  wire [FW-1:0] vbe  = act[4][DW-1:FW];
  wire [FW-1:0] vss  = act[5][FW-1:0];
  wire [FW-1:0] vse  = act[5][DW-1:FW];

  wire h_last = h >= htot;
  wire v_last = v >= vtot;
  wire wrap   = h_last && v_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      unlocked <= 1'b0;
      ctrl     <= '0;
    end else begin
      if (cfg_we && cfg_addr == AW'(A_LOCK))
        unlocked <= (cfg_wdata == UNLOCK_KEY);
      if (wr_ok && cfg_addr == AW'(A_CTRL))
        ctrl <= cfg_wdata[CTRL_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
      act  <= '0;
    end else begin
      if (!en || wrap)
        act <= pend;
      for (int i = 0; i < NT; i++) begin
        if (wr_ok && cfg_addr == AW'(A_TIM + i)) begin
          pend[i] <= cfg_wdata;
          if (upd) act[i] <= cfg_wdata;
        end
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr == AW'(A_LOCK)) cfg_rdata[0] = unlocked;
    if (cfg_addr == AW'(A_CTRL)) cfg_rdata[CTRL_W-1:0] = ctrl;
    for (int i = 0; i < NT; i++)
      if (cfg_addr == AW'(A_TIM + i)) cfg_rdata = pend[i];
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      h <= '0;
      v <= '0;
    end else if (h_last) begin
      h <= '0;
      v <= v_last ? '0 : v + 1'b1;
    end else begin
      h <= h + 1'b1;
    end
  end

  logic vid_on, hs_on, vs_on;
  always_comb begin
    case (pwr_state)
      3'd0:    {vid_on, hs_on, vs_on} = 3'b111;
      3'd1:    {vid_on, hs_on, vs_on} = 3'b011;
      3'd2:    {vid_on, hs_on, vs_on} = 3'b010;
      3'd3:    {vid_on, hs_on, vs_on} = 3'b001;
      default: {vid_on, hs_on, vs_on} = 3'b000;
    endcase
  end
  wire panel_req = pwr_state <= 3'd3;

  wire h_blk = h > hbs && h <= hbe;
  wire v_blk = v > vbs && v <= vbe;
  wire h_syn = h > hss && h <= hse;
  wire v_syn = v > vss && v <= vse;

  always_ff @(posedge clk) begin
    if (rst) begin
      hcount       <= '0;
      vcount       <= '0;
      hsync        <= 1'b1;
      vsync        <= 1'b1;
      blank        <= 1'b1;
      video_active <= 1'b0;
      dac_pwrdn    <= 1'b1;
      panel_on     <= 1'b0;
    end else begin
      hcount       <= en ? h : '0;
      vcount       <= en ? v : '0;
      hsync        <= (en && hs_on && h_syn) ? hpol : !hpol;
      vsync        <= (en && vs_on && v_syn) ? vpol : !vpol;
      blank        <= !en || h_blk || v_blk || !vid_on;
      video_active <= en && h <= hact && v <= vact;
      dac_pwrdn    <= !(hs_on && vs_on);
      panel_on     <= panel_req;
    end
  end

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (blank && dac_pwrdn && !panel_on && !video_active && hcount == '0 && vcount == '0));

  assert_locked_ignore_R3: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && !unlocked && cfg_addr != AW'(A_LOCK)) |=> (pend == $past(pend) && ctrl == $past(ctrl)));

  assert_hold_zero_R4: assert property (@(posedge clk) disable iff (rst)
    !en |=> (h == '0 && v == '0));

  assert_idle_sync_R4: assert property (@(posedge clk) disable iff (rst)
    !en |=> (blank && hsync == !$past(hpol) && vsync == !$past(vpol)));

  assert_pixel_step_R5: assert property (@(posedge clk) disable iff (rst)
    (en && h < htot) |=> h == $past(h) + 1'b1);

  assert_line_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (en && !h_last) |=> $stable(v));

  assert_dac_panel_R8: assert property (@(posedge clk) disable iff (rst)
    !dac_pwrdn |-> panel_on);
endmodule

// File: tb/raster_timing_gen_test.sv
module raster_timing_gen_test;
  localparam logic [31:0] KEY = 32'h0000_A5C3;

  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we;
  logic [3:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic [2:0]  pwr_state;
  logic [15:0] hcount, vcount;
  logic        hsync, vsync, blank, video_active, dac_pwrdn, panel_on;

  always #2 clk = ~clk;

  raster_timing_gen uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pwr_state(pwr_state),
    .hcount(hcount), .vcount(vcount), .hsync(hsync), .vsync(vsync),
    .blank(blank), .video_active(video_active), .dac_pwrdn(dac_pwrdn),
    .panel_on(panel_on)
  );

  int total = 0;
  int bad = 0;
  string phase = "";
  bit running = 0;
  bit m_unl = 0, m_en = 0, m_hpol = 0, m_vpol = 0, m_upd = 0;
  logic [31:0] m_pend [6];
  logic [31:0] m_act  [6];
  int rh = 0, rv = 0;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s got=%0h exp=%0h", phase, tag, got, exp);
    end
  endtask

  function automatic logic [2:0] pmode(input logic [2:0] s);
    case (s)
      3'd0: return 3'b111;
      3'd1: return 3'b011;
      3'd2: return 3'b010;
      3'd3: return 3'b001;
      default: return 3'b000;
    endcase
  endfunction

  task automatic tick();
    int htot, hact, hbs, hbe, hss, hse, vtot, vact, vbs, vbe, vss, vse;
    logic [2:0] pm;
    logic hb, vb;
    @(posedge clk);
    @(negedge clk);
    if (running) begin
      hact = m_act[0][15:0]; htot = m_act[0][31:16];
      hbs  = m_act[1][15:0]; hbe  = m_act[1][31:16];
      hss  = m_act[2][15:0]; hse  = m_act[2][31:16];
      vact = m_act[3][15:0]; vtot = m_act[3][31:16];
      vbs  = m_act[4][15:0]; vbe  = m_act[4][31:16];
      vss  = m_act[5][15:0]; vse  = m_act[5][31:16];
      pm = pmode(pwr_state);
      hb = rh > hbs && rh <= hbe;
      vb = rv > vbs && rv <= vbe;
      chk("R5 R11 hcount", 32'(hcount), 32'(rh));
      chk("R5 R11 vcount", 32'(vcount), 32'(rv));
      chk("R7 hsync", 32'(hsync), 32'((pm[1] && rh > hss && rh <= hse) ? m_hpol : !m_hpol));
      chk("R7 vsync", 32'(vsync), 32'((pm[0] && rv > vss && rv <= vse) ? m_vpol : !m_vpol));
      chk("R6 blank", 32'(blank), 32'(hb || vb || !pm[2]));
      chk("R10 video_active", 32'(video_active), 32'(rh <= hact && rv <= vact));
      chk("R8 dac_pwrdn", 32'(dac_pwrdn), 32'(!(pm[1] && pm[0])));
      chk("R8 panel_on", 32'(panel_on), 32'(pwr_state <= 3'd3));
      if (rh >= htot) begin
        rh = 0;
        if (rv >= vtot) begin
          rv = 0;
          m_act = m_pend;
        end else rv++;
      end else rh++;
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a[3:0]; cfg_wdata = d;
    tick();
    cfg_we = 1'b0;
    if (a == 0) m_unl = (d == KEY);
    else if (m_unl) begin
      if (a == 1) begin
        if (d[0] && !m_en) begin m_act = m_pend; rh = 0; rv = 0; running = 1; end
        if (!d[0]) running = 0;
        m_en = d[0]; m_hpol = d[1]; m_vpol = d[2]; m_upd = d[3];
      end else if (a >= 2 && a < 8) begin
        m_pend[a-2] = d;
        if (m_upd || !m_en) m_act[a-2] = d;
      end
    end
  endtask

  task automatic rd(input string tag, input int a, input logic [31:0] exp);
    cfg_addr = a[3:0];
    #1;
    chk(tag, cfg_rdata, exp);
  endtask

  task automatic walk(input int n);
    repeat (n) tick();
  endtask

  task automatic test_reset();
    phase = "R1";
    rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; pwr_state = 3'd0;
    repeat (3) @(negedge clk);
    chk("R1 hcount", 32'(hcount), 0);
    chk("R1 vcount", 32'(vcount), 0);
    chk("R1 blank", 32'(blank), 1);
    chk("R1 video_active", 32'(video_active), 0);
    chk("R1 hsync", 32'(hsync), 1);
    chk("R1 vsync", 32'(vsync), 1);
    chk("R1 dac_pwrdn", 32'(dac_pwrdn), 1);
    chk("R1 panel_on", 32'(panel_on), 0);
    rst = 1'b0;
    tick();
    rd("R3 locked after reset", 0, 0);
  endtask

  task automatic test_lock();
    phase = "R3";
    wr(1, 32'h6);
    rd("R3 ctrl write ignored", 1, 0);
    wr(2, 32'h1234_5678);
    rd("R3 timing write ignored", 2, 0);
    wr(0, KEY);
    rd("R3 unlocked", 0, 1);
    phase = "R2";
    wr(2, 32'h0009_0003); wr(3, 32'h0009_0003); wr(4, 32'h0008_0005);
    wr(5, 32'h0006_0002); wr(6, 32'h0006_0002); wr(7, 32'h0005_0003);
    rd("R2 htotal word", 2, 32'h0009_0003);
    rd("R2 hsync word", 4, 32'h0008_0005);
    rd("R2 vblank word", 6, 32'h0006_0002);
    rd("R2 vsync word", 7, 32'h0005_0003);
    rd("R2 unused address", 9, 0);
    phase = "R3";
    wr(0, KEY ^ 32'h1);
    rd("R3 relocked", 0, 0);
    wr(4, 32'h0001_0001);
    rd("R3 locked write kept old word", 4, 32'h0008_0005);
    wr(0, KEY);
  endtask

  task automatic test_disabled();
    phase = "R4";
    repeat (4) begin
      tick();
      chk("R4 hcount", 32'(hcount), 0);
      chk("R4 vcount", 32'(vcount), 0);
      chk("R4 blank", 32'(blank), 1);
      chk("R4 hsync idle", 32'(hsync), 1);
    end
  endtask

  task automatic test_frame();
    phase = "R5";
    pwr_state = 3'd0;
    wr(1, 32'h1);
    walk(140);
  endtask

  task automatic test_polarity();
    phase = "R7";
    wr(1, 32'h3);
    walk(70);
    wr(1, 32'h5);
    walk(70);
    wr(1, 32'h1);
  endtask

  task automatic test_power();
    phase = "R8";
    for (int s = 0; s < 8; s++) begin
      pwr_state = s[2:0];
      walk(70);
    end
    pwr_state = 3'd0;
  endtask

  task automatic test_update();
    phase = "R9";
    while (!(rv == 1 && rh == 2)) tick();
    wr(2, 32'h000B_0003);
    wr(3, 32'h000B_0003);
    wr(4, 32'h0009_0006);
    rd("R9 deferred word stored", 2, 32'h000B_0003);
    walk(160);
    wr(1, 32'h9);
    while (!(rv == 2 && rh == 5)) tick();
    wr(7, 32'h0006_0004);
    wr(2, 32'h0009_0003);
    wr(3, 32'h0009_0003);
    walk(150);
  endtask

  task automatic test_stop();
    phase = "R4";
    wr(1, 32'h2);
    tick();
    chk("R4 stop hcount", 32'(hcount), 0);
    chk("R4 stop vcount", 32'(vcount), 0);
    chk("R4 stop blank", 32'(blank), 1);
    chk("R4 stop hsync idle high-pol", 32'(hsync), 0);
    tick();
    chk("R4 still zero", 32'(hcount), 0);
  endtask

  initial begin
    for (int i = 0; i < 6; i++) begin m_pend[i] = '0; m_act[i] = '0; end
    test_reset();
    test_lock();
    test_disabled();
    test_frame();
    test_polarity();
    test_power();
    test_update();
    test_stop();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog R1 got=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule